// File: doc/BRIEF.md
# MDIO Management Frame Responder

This block answers serial management frames on the PHY side of a management link. The link is driven by software rather than by a hardware master. A host updates a 4-bit control word through a simple write strobe. The word carries a serial clock bit, an output-enable bit, a host data bit and a data bit that the block returns. The block acts only when a write moves the clock bit from low to high. On that edge it shifts a qualified host bit into a 32-bit history.

A run of 32 ones in the history arms a countdown. Sixteen edges later, the block decodes the header that just arrived. A read header loads the addressed 16-bit register into a shifter. Over the next sixteen edges the shifter is presented on the returned data bit, most significant bit first. A write header is accepted and its data is thrown away. The register bank holds 32 entries of 16 bits. It comes out of reset with identifier values in entries 2 and 3, and every PHY address gets an answer.

Top module: `mdio_resp`

## Requirements
- R1: Control word layout: bit 0 host data, bit 1 returned data, bit 2 output enable, bit 3 clock. The returned-data bit is read-only, so a host write never changes it.
- R2: The block acts only on a write that takes the clock bit from 0 to 1. A write that leaves the clock high, even with new data, shifts nothing.
- R3: The shifted bit is 1 only when host data and output enable are both set in the same write.
- R4: When the history holds 32 consecutive ones, the countdown re-arms. Any number of ones at or above 32 works as a preamble.
- R5: The 16th bit after the preamble completes the header. The start field (header bits 15:14) must be 01. The opcode (bits 13:12) is 01 for write and 10 for read. Other values give no response.
- R6: A read is accepted only when header bit 0 (the low turnaround bit) is 0. A write is accepted only when bits 1:0 equal 10.
- R7: An accepted read returns the register picked by header bits 6:2. The value appears MSB first on the returned-data bit, one bit per rising edge, starting with the 17th edge after the preamble.
- R8: Write frames do not change the register bank. A later read returns the value the register had before the write.
- R9: After reset, the control word reads 0. Register 2 holds 0x0022, register 3 holds 0x161A, and every other register holds 0.
- R10: Every PHY address (header bits 11:7) is answered the same way.
- R11: After 32 edges past the preamble the frame ends and the block goes idle. A header sent with no fresh preamble is not decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| ctl_we_i | input | 1 | Control word write strobe |
| ctl_wdata_i | input | 4 | Control word write value |
| ctl_rdata_o | output | 4 | Control word readback, including the returned-data bit |

## Verification
The bench goes after the corner cases below.
- Repeated writes with the clock held high. A design that treats a level as an edge would shift extra bits and misalign the header.
- A preamble sent with output enable low. A design that ignores the enable would resync and answer.
- A read whose low turnaround bit is 1, and headers with a bad start field or opcode. A loose decoder would stream register data for these.
- A header with no fresh preamble after a completed frame. A counter that wraps instead of expiring would answer it.
- A write to an identifier register followed by a read of it. A bank that stores writes would return the new data.

// File: rtl/mdio_resp_pkg.sv
package mdio_resp_pkg;
  localparam int CTL_W    = 4;
  localparam int DOUT_BIT = 0;
  localparam int DIN_BIT  = 1;
  localparam int OE_BIT   = 2;
  localparam int CLK_BIT  = 3;

  localparam int ADDR_W   = 5;

  localparam logic [1:0] START_CODE = 2'b01;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] TA_WRITE   = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } frame_state_e;
endpackage

// File: rtl/mdio_resp_ctl.sv
module mdio_resp_ctl
  import mdio_resp_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [CTL_W-1:0] wdata_i,
  input  logic             din_set_i,
  input  logic             din_val_i,
  output logic [CTL_W-1:0] ctl_o,
  output logic             edge_o,
  output logic             bit_o
);
  logic [CTL_W-1:0] ctl_q;
  logic             din_nx;

  // previous clock bit lives in ctl_q; writes are already synchronous
  assign edge_o = we_i && wdata_i[CLK_BIT] && !ctl_q[CLK_BIT];
  assign bit_o  = wdata_i[DOUT_BIT] && wdata_i[OE_BIT];
  assign din_nx = din_set_i ? din_val_i : ctl_q[DIN_BIT];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctl_q <= '0;
    end else if (we_i) begin
      ctl_q[CLK_BIT]  <= wdata_i[CLK_BIT];
      ctl_q[OE_BIT]   <= wdata_i[OE_BIT];
      ctl_q[DOUT_BIT] <= wdata_i[DOUT_BIT];
      ctl_q[DIN_BIT]  <= din_nx;
    end
  end

  assign ctl_o = ctl_q;

  AST_DIN_READONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !din_set_i) |=> (ctl_q[DIN_BIT] == $past(ctl_q[DIN_BIT]))); // R1

  AST_IDLE_WORD_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ctl_q)); // R2
endmodule

// File: rtl/mdio_resp_regs.sv
module mdio_resp_regs
  import mdio_resp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter logic [DATA_W-1:0] ID_HI = 16'h0022,
  parameter logic [DATA_W-1:0] ID_LO = 16'h161A
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i
);
  localparam int NUM_REGS = 1 << ADDR_W;
  localparam int ID_HI_IDX = 2;
  localparam int ID_LO_IDX = 3;

  logic [DATA_W-1:0] regs_q [NUM_REGS];

  function automatic logic [DATA_W-1:0] reset_val(input int idx);
    if (idx == ID_HI_IDX) return ID_HI;
    if (idx == ID_LO_IDX) return ID_LO;
    return '0;
  endfunction

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_q[i] <= reset_val(i);
      else         regs_q[i] <= regs_q[i];
    end
  end

  assign rd_data_o = regs_q[rd_addr_i];

  // write frames are accepted on the wire and discarded here
  logic unused_wr;
  assign unused_wr = ^{wr_en_i, wr_addr_i, wr_data_i};

  AST_BANK_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> $stable(rd_data_o) || $changed(rd_addr_i)); // R8
endmodule

// File: rtl/mdio_resp_frame.sv
module mdio_resp_frame
  import mdio_resp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              edge_i,
  input  logic              bit_i,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              din_set_o,
  output logic              din_val_o,
  output logic              wr_fire_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o
);
  localparam int HIST_W = 2 * DATA_W;
  localparam int CNT_W  = $clog2(HIST_W) + 2;
  localparam logic signed [CNT_W-1:0] CNT_SYNC = CNT_W'(HIST_W);
  localparam logic signed [CNT_W-1:0] CNT_DEC  = CNT_W'(DATA_W);
  localparam logic signed [CNT_W-1:0] CNT_DONE = '0;
  localparam logic signed [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
  localparam logic signed [CNT_W-1:0] CNT_EXP  = '1;

  logic [HIST_W-1:0]        hist_q, hist_nx;
  logic signed [CNT_W-1:0]  cnt_q, cnt_eff, cnt_nx;
  frame_state_e             state_q, st_mid, st_nx;
  logic [DATA_W-1:0]        shift_q, shift_mid, shift_nx;
  logic [ADDR_W-1:0]        phy_q, reg_q;
  logic [DATA_W-1:0]        hdr;
  logic                     at_dec, rd_ok, wr_ok, drive, commit;

  assign hist_nx = {hist_q[HIST_W-2:0], bit_i};
  assign cnt_eff = (hist_nx == '1) ? CNT_SYNC : cnt_q;
  assign hdr     = hist_nx[DATA_W-1:0];
  assign at_dec  = (cnt_eff == CNT_DEC);

  assign rd_ok = (hdr[15:14] == START_CODE) && (hdr[13:12] == OP_READ) && !hdr[0];
  assign wr_ok = (hdr[15:14] == START_CODE) && (hdr[13:12] == OP_WRITE) &&
                 (hdr[1:0] == TA_WRITE);

  assign rd_addr_o = hdr[6:2];

  always_comb begin
    st_mid = state_q;
    if (at_dec) begin
      if (wr_ok)      st_mid = ST_WR;
      else if (rd_ok) st_mid = ST_RD;
      else            st_mid = ST_IDLE;
    end
  end

  assign shift_mid = (at_dec && rd_ok) ? rd_data_i : shift_q;
  assign drive     = (st_mid == ST_RD) && (cnt_eff < CNT_DEC);
  assign shift_nx  = drive ? {shift_mid[DATA_W-2:0], 1'b0} : shift_mid;
  assign commit    = (cnt_eff == CNT_DONE) && (st_mid != ST_IDLE);
  assign st_nx     = commit ? ST_IDLE : st_mid;
  // saturate at the expired value so a stale count never re-arms
  assign cnt_nx    = (cnt_eff == CNT_EXP) ? CNT_EXP : cnt_eff - CNT_ONE;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hist_q  <= '0;
      cnt_q   <= CNT_EXP;
      state_q <= ST_IDLE;
      shift_q <= '0;
      phy_q   <= '0;
      reg_q   <= '0;
    end else if (edge_i) begin
      hist_q  <= hist_nx;
      cnt_q   <= cnt_nx;
      state_q <= st_nx;
      shift_q <= shift_nx;
      if (at_dec && (rd_ok || wr_ok)) begin
        phy_q <= hdr[11:7];
        reg_q <= hdr[6:2];
      end
    end
  end

  assign din_set_o = edge_i && drive;
  assign din_val_o = shift_mid[DATA_W-1];
  assign wr_fire_o = edge_i && commit && (st_mid == ST_WR);
  assign wr_addr_o = reg_q;
  assign wr_data_o = hdr;

  // PHY address is latched but every address answers
  logic unused_phy;
  assign unused_phy = ^phy_q;

  AST_NO_EDGE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !edge_i |=> ($stable(hist_q) && $stable(cnt_q) && $stable(state_q))); // R2

  AST_SYNC_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && (hist_nx == '1)) |=> (cnt_q == CNT_SYNC - CNT_ONE)); // R4

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q >= CNT_EXP) && (cnt_q < CNT_SYNC)); // R4

  AST_READ_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RD) |-> ((cnt_q < CNT_DEC) && (cnt_q >= CNT_DONE))); // R7

  AST_FRAME_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && (cnt_q == CNT_DONE)) |=> (state_q == ST_IDLE)); // R11

  AST_ADDR_LATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (edge_i && at_dec && (rd_ok || wr_ok)) |=> (reg_q == $past(hdr[6:2]))); // R7
endmodule

// File: rtl/mdio_resp.sv
module mdio_resp
  import mdio_resp_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctl_we_i,
  input  logic [CTL_W-1:0] ctl_wdata_i,
  output logic [CTL_W-1:0] ctl_rdata_o
);
  logic              edge_w, bit_w, din_set_w, din_val_w, wr_fire_w;
  logic [ADDR_W-1:0] rd_addr_w, wr_addr_w;
  logic [DATA_W-1:0] rd_data_w, wr_data_w;

  mdio_resp_ctl u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (ctl_we_i),
    .wdata_i   (ctl_wdata_i),
    .din_set_i (din_set_w),
    .din_val_i (din_val_w),
    .ctl_o     (ctl_rdata_o),
    .edge_o    (edge_w),
    .bit_o     (bit_w)
  );

  mdio_resp_frame #(.DATA_W(DATA_W)) u_frame (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .edge_i    (edge_w),
    .bit_i     (bit_w),
    .rd_addr_o (rd_addr_w),
    .rd_data_i (rd_data_w),
    .din_set_o (din_set_w),
    .din_val_o (din_val_w),
    .wr_fire_o (wr_fire_w),
    .wr_addr_o (wr_addr_w),
    .wr_data_o (wr_data_w)
  );

  mdio_resp_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_addr_i (rd_addr_w),
    .rd_data_o (rd_data_w),
    .wr_en_i   (wr_fire_w),
    .wr_addr_i (wr_addr_w),
    .wr_data_i (wr_data_w)
  );
endmodule

// File: tb/mdio_resp_tb_top.sv
`timescale 1ns/1ps
module mdio_resp_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       we = 1'b0;
  logic [3:0] wdata = '0;
  logic [3:0] rdata;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mdio_resp dut_i (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .ctl_we_i    (we),
    .ctl_wdata_i (wdata),
    .ctl_rdata_o (rdata)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] w);
    @(negedge clk);
    we = 1'b1;
    wdata = w;
    @(negedge clk);
    we = 1'b0;
  endtask

  // din written as 1 every time: it must never reach the readback
  task automatic send_bit(input logic b, input logic oe, input bit dbl);
    wr({1'b0, oe, 1'b1, b});
    wr({1'b1, oe, 1'b1, b});
    if (dbl) wr({1'b1, oe, 1'b1, ~b});
  endtask

  task automatic read_frame(input string tag, input int pre_n, input logic pre_oe,
                            input logic [1:0] st, input logic [1:0] op,
                            input logic [4:0] phy, input logic [4:0] ra,
                            input logic [1:0] ta, input logic ta_oe, input bit dbl,
                            input logic [15:0] exp);
    logic [13:0] hdr;
    logic [15:0] got;
    hdr = {st, op, phy, ra};
    for (int i = 0; i < pre_n; i++) send_bit(1'b1, pre_oe, dbl);
    for (int i = 13; i >= 0; i--) send_bit(hdr[i], 1'b1, dbl);
    send_bit(ta[1], ta_oe, dbl);
    send_bit(ta[0], ta_oe, dbl);
    got = '0;
    for (int i = 15; i >= 0; i--) begin
      send_bit(1'b0, 1'b0, dbl);
      got[i] = rdata[1];
    end
    check(tag, got, exp);
  endtask

  task automatic write_frame(input logic [4:0] phy, input logic [4:0] ra,
                             input logic [15:0] d);
    logic [31:0] f;
    f = {2'b01, 2'b01, phy, ra, 2'b10, d};
    for (int i = 0; i < 32; i++) send_bit(1'b1, 1'b1, 1'b0);
    for (int i = 31; i >= 0; i--) send_bit(f[i], 1'b1, 1'b0);
  endtask

  task automatic t_reset;
    check("R9 reset control word", {12'h0, rdata}, 16'h0);
  endtask

  task automatic t_readonly;
    wr(4'b1111);
    check("R1 din ignored on write", {12'h0, rdata}, 16'h000D);
    wr(4'b0010);
    check("R1 din ignored, fields clear", {12'h0, rdata}, 16'h0000);
  endtask

  task automatic t_reads;
    read_frame("R9 R7 read reg2", 32, 1'b1, 2'b01, 2'b10, 5'd0, 5'd2, 2'b00, 1'b0, 1'b0, 16'h0022);
    read_frame("R10 R9 read reg3 phy31", 32, 1'b1, 2'b01, 2'b10, 5'd31, 5'd3, 2'b00, 1'b0, 1'b0, 16'h161A);
    read_frame("R9 read reg5 zero", 32, 1'b1, 2'b01, 2'b10, 5'd7, 5'd5, 2'b00, 1'b0, 1'b0, 16'h0000);
    read_frame("R4 long preamble", 45, 1'b1, 2'b01, 2'b10, 5'd1, 5'd3, 2'b00, 1'b0, 1'b0, 16'h161A);
    read_frame("R6 read ta 10 driven", 32, 1'b1, 2'b01, 2'b10, 5'd3, 5'd3, 2'b10, 1'b1, 1'b0, 16'h161A);
  endtask

  task automatic t_rejects;
    read_frame("R3 preamble without oe", 32, 1'b0, 2'b01, 2'b10, 5'd0, 5'd3, 2'b00, 1'b0, 1'b0, 16'h0000);
    read_frame("R6 read ta bit0 set", 32, 1'b1, 2'b01, 2'b10, 5'd0, 5'd3, 2'b01, 1'b1, 1'b0, 16'h0000);
    read_frame("R5 opcode 11", 32, 1'b1, 2'b01, 2'b11, 5'd0, 5'd3, 2'b00, 1'b0, 1'b0, 16'h0000);
    read_frame("R5 start 00", 32, 1'b1, 2'b00, 2'b10, 5'd0, 5'd3, 2'b00, 1'b0, 1'b0, 16'h0000);
  endtask

  task automatic t_level_clock;
    read_frame("R2 clock held high", 32, 1'b1, 2'b01, 2'b10, 5'd9, 5'd3, 2'b00, 1'b0, 1'b1, 16'h161A);
  endtask

  task automatic t_write_discard;
    write_frame(5'd0, 5'd3, 16'hFFFF);
    read_frame("R8 write discarded reg3", 32, 1'b1, 2'b01, 2'b10, 5'd0, 5'd3, 2'b00, 1'b0, 1'b0, 16'h161A);
    write_frame(5'd4, 5'd2, 16'h5A5A);
    read_frame("R8 write discarded reg2", 32, 1'b1, 2'b01, 2'b10, 5'd4, 5'd2, 2'b00, 1'b0, 1'b0, 16'h0022);
  endtask

  task automatic t_no_resync;
    read_frame("R11 frame before", 32, 1'b1, 2'b01, 2'b10, 5'd0, 5'd2, 2'b00, 1'b0, 1'b0, 16'h0022);
    read_frame("R11 header without preamble", 0, 1'b1, 2'b01, 2'b10, 5'd0, 5'd3, 2'b00, 1'b0, 1'b0, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readonly();
    t_reads();
    t_rejects();
    t_level_clock();
    t_write_discard();
    t_no_resync();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule